// File: doc/BRIEF.md
# Power Sequencing Script Engine

This block keeps a small byte-wide script store and plays back power-state transition scripts. A script is a chain of linked instructions. Each instruction carries a 16-bit power-bus message, a one-byte delay and the index of the instruction that follows it. A host loads the store one byte at a time through a configuration port. It writes a byte address to one selector and then the byte itself to another. It also programs the start index of each script and sets two option bits for each processor.

Sleep, wake and warm-reset requests come in on dedicated inputs. Three processor lanes supply the wake and warm-reset requests. When the engine is idle, one request is granted by a fixed priority, and the engine fetches the instruction at that script's start index. It sends the message with a one-cycle strobe, counts the delay in ticks of an internal divided clock, and then follows the link. A link value of all ones ends the script.

Top module: `pwr_script_engine`

## Requirements
- R1: Configuration selectors on `cfg_sel`: 0 = byte address, 1 = store byte at the held address, 2 = sleep start index, 3 = wake start index shared by lanes 0 and 1, 4 = wake start index of lane 2, 5 = warm start index, 6/7/8 = option byte of lanes 0/1/2. Other selector values have no effect. Instruction i occupies bytes 4i..4i+3, holding in order the message high byte, the message low byte, the delay and the next index.
- R2: A request granted in idle cycle N raises `busy` after edge N. The message of the start instruction appears on `msg` with `msg_valid` high for exactly one cycle, after edge N+1.
- R3: After a strobe, the engine decrements the loaded delay once per tick, where a tick comes every TICK_DIV clocks counted from reset. The next fetch, or the end of the script, follows one cycle after the count reaches zero. A delay of 0 gives strobes two cycles apart.
- R4: Only the low 6 bits of the next-index byte are used. The value 0x3F ends the script, and `busy` falls once that instruction's delay has run out. Links need not be consecutive.
- R5: Priority is warm reset, then wake, then sleep. `run_kind` holds the granted script while busy: 0 sleep, 1 wake of lane 0 or 1, 2 wake of lane 2, 3 warm reset.
- R6: A wake request from lane 0 or 1 starts at the shared wake index. A wake request from lane 2 starts at its own index.
- R7: A warm request from a lane is honoured only if bit 4 of that lane's option byte is 1. Otherwise it has no effect.
- R8: With bit 3 of a lane's option byte set, a high wake level is a request on every idle cycle. With bit 3 clear, only a rising edge is a request.
- R9: Requests are evaluated only while idle. They are not queued, so a wake edge that arrives while busy is lost.
- R10: A configuration write while busy changes nothing and sets `cfg_err`. `cfg_err` stays set until reset.
- R11: After reset, `busy`, `msg_valid` and `cfg_err` are 0.
- R12: A configuration write in the same idle cycle as a granted request takes effect, but the granted run uses the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration selector (R1) |
| cfg_wdata | input | 8 | Configuration write data |
| sleep_req | input | 1 | Sleep request, level |
| wake_req | input | NPROC | Wake request per lane |
| warm_req | input | NPROC | Warm-reset request per lane |
| msg_valid | output | 1 | One-cycle message strobe |
| msg | output | 16 | Power-bus message |
| run_kind | output | 2 | Script being run |
| busy | output | 1 | Script in progress |
| cfg_err | output | 1 | Sticky write-while-busy flag |

## Verification
Two collisions matter here. The first is a configuration write landing in the same idle cycle as a granted request. The bench drives `sleep_req` and a write to the sleep start index on one edge. The run must replay the old script, and the next run the new one. The second collision is between the request inputs themselves. Warm, a lane 2 wake edge and sleep rise together, so warm must win, the lost wake edge must not replay, and sleep must follow. A behavioural model compared on every clock judges `busy`, `msg_valid`, `msg`, `run_kind` and `cfg_err` in both cases.

// File: rtl/pse_pkg.sv
package pse_pkg;
   localparam int SEL_W = 4;
   localparam logic [SEL_W-1:0] SEL_MEM_ADDR        = 4'd0;
   localparam logic [SEL_W-1:0] SEL_MEM_DATA        = 4'd1;
   localparam logic [SEL_W-1:0] SEL_START_SLEEP     = 4'd2;
   localparam logic [SEL_W-1:0] SEL_START_WAKE_SH   = 4'd3;
   localparam logic [SEL_W-1:0] SEL_START_WAKE_LAST = 4'd4;
   localparam logic [SEL_W-1:0] SEL_START_WARM      = 4'd5;
   localparam logic [SEL_W-1:0] SEL_OPT_BASE        = 4'd6;
   localparam int LEVEL_BIT   = 3;
   localparam int WARM_EN_BIT = 4;

   typedef enum logic [1:0] {
      RUN_SLEEP     = 2'd0,
      RUN_WAKE_SH   = 2'd1,
      RUN_WAKE_LAST = 2'd2,
      RUN_WARM      = 2'd3
   } run_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_WAIT  = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic [15:0] msg;
      logic [7:0]  delay;
      logic [7:0]  next;
   } script_ins_t;
endpackage

// File: rtl/pse_cfg_regs.sv
module pse_cfg_regs
   import pse_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int NPROC  = 3,
   parameter int ADDR_W = IDX_W + 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic [IDX_W-1:0]  start_sleep,
   output logic [IDX_W-1:0]  start_wake_sh,
   output logic [IDX_W-1:0]  start_wake_last,
   output logic [IDX_W-1:0]  start_warm,
   output logic [NPROC-1:0]  lvl_en,
   output logic [NPROC-1:0]  warm_en,
   output logic              cfg_err
);
   logic              wr_ok;
   logic [ADDR_W-1:0] addr_q;

   assign wr_ok     = cfg_we & ~busy;
   assign mem_we    = wr_ok && (cfg_sel == SEL_MEM_DATA);
   assign mem_waddr = addr_q;
   assign mem_wdata = cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q          <= '0;
         start_sleep     <= '0;
         start_wake_sh   <= '0;
         start_wake_last <= '0;
         start_warm      <= '0;
      end else if (wr_ok) begin
         unique case (cfg_sel)
            SEL_MEM_ADDR:        addr_q          <= cfg_wdata[ADDR_W-1:0];
            SEL_START_SLEEP:     start_sleep     <= cfg_wdata[IDX_W-1:0];
            SEL_START_WAKE_SH:   start_wake_sh   <= cfg_wdata[IDX_W-1:0];
            SEL_START_WAKE_LAST: start_wake_last <= cfg_wdata[IDX_W-1:0];
            SEL_START_WARM:      start_warm      <= cfg_wdata[IDX_W-1:0];
            default: ;
         endcase
      end
   end

   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_opt
         localparam logic [SEL_W-1:0] MY_SEL = SEL_OPT_BASE + SEL_W'(p);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_en[p]  <= 1'b0;
               warm_en[p] <= 1'b0;
            end else if (wr_ok && cfg_sel == MY_SEL) begin
               lvl_en[p]  <= cfg_wdata[LEVEL_BIT];
               warm_en[p] <= cfg_wdata[WARM_EN_BIT];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_err <= 1'b0;
      else if (cfg_we && busy)   cfg_err <= 1'b1;
   end

   // R10
   busy_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && busy) |=> cfg_err);
   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R10
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && busy) |=> ($stable(start_sleep) && $stable(start_warm)
                            && $stable(start_wake_sh) && $stable(start_wake_last)
                            && $stable(lvl_en) && $stable(warm_en)));
endmodule

// File: rtl/pse_script_mem.sv
module pse_script_mem
   import pse_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int ADDR_W = IDX_W + 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [IDX_W-1:0]  ridx,
   output script_ins_t       rins
);
   localparam int NUM_BYTES = 4 << IDX_W;

   logic [7:0] mem_q [NUM_BYTES];
   logic [7:0] lane  [4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   generate
      for (genvar k = 0; k < 4; k++) begin : g_lane
         assign lane[k] = mem_q[{ridx, 2'(k)}];
      end
   endgenerate

   assign rins = '{msg: {lane[0], lane[1]}, delay: lane[2], next: lane[3]};
endmodule

// File: rtl/pse_event_arb.sv
module pse_event_arb
   import pse_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int NPROC = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic             sleep_req,
   input  logic [NPROC-1:0] wake_req,
   input  logic [NPROC-1:0] warm_req,
   input  logic [NPROC-1:0] lvl_en,
   input  logic [NPROC-1:0] warm_en,
   input  logic [IDX_W-1:0] start_sleep,
   input  logic [IDX_W-1:0] start_wake_sh,
   input  logic [IDX_W-1:0] start_wake_last,
   input  logic [IDX_W-1:0] start_warm,
   output logic             grant,
   output run_kind_e        grant_kind,
   output logic [IDX_W-1:0] grant_start
);
   logic [NPROC-1:0] prev_q;
   logic [NPROC-1:0] wake_hit;
   logic [NPROC-1:0] warm_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= wake_req;
   end

   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_hit
         assign wake_hit[p] = wake_req[p] & (lvl_en[p] | ~prev_q[p]);
         assign warm_hit[p] = warm_req[p] & warm_en[p];
      end
   endgenerate

   always_comb begin
      grant       = 1'b0;
      grant_kind  = RUN_SLEEP;
      grant_start = start_sleep;
      if (|warm_hit) begin
         grant       = idle;
         grant_kind  = RUN_WARM;
         grant_start = start_warm;
      end else if (|wake_hit) begin
         grant = idle;
         if (|wake_hit[NPROC-2:0]) begin
            grant_kind  = RUN_WAKE_SH;
            grant_start = start_wake_sh;
         end else begin
            grant_kind  = RUN_WAKE_LAST;
            grant_start = start_wake_last;
         end
      end else if (sleep_req) begin
         grant = idle;
      end
   end

   // R5
   warm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && |(warm_req & warm_en)) |-> (grant && grant_kind == RUN_WARM));
   // R8
   edge_only_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_req && (warm_req & warm_en) == '0 &&
       (wake_req & ~(prev_q & ~lvl_en)) == '0) |-> !grant);
   // R9
   no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> idle);
endmodule

// File: rtl/pse_sequencer.sv
module pse_sequencer
   import pse_pkg::*;
#(
   parameter int IDX_W    = 6,
   parameter int TICK_DIV = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant,
   input  run_kind_e        grant_kind,
   input  logic [IDX_W-1:0] grant_start,
   input  script_ins_t      rins,
   output logic [IDX_W-1:0] ridx,
   output logic             busy,
   output logic             msg_valid,
   output logic [15:0]      msg,
   output run_kind_e        run_kind
);
   localparam logic [IDX_W-1:0] SENT = '1;

   logic tick;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_LAST);
      end
   endgenerate

   seq_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] nxt_q;
   logic [7:0]       cnt_q;
   logic [IDX_W-1:0] rnext;
   logic             unused_next_hi;

   assign rnext          = rins.next[IDX_W-1:0];
   assign unused_next_hi = ^rins.next[7:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         idx_q     <= '0;
         nxt_q     <= '0;
         cnt_q     <= '0;
         msg_valid <= 1'b0;
         msg       <= '0;
         run_kind  <= RUN_SLEEP;
      end else begin
         msg_valid <= 1'b0;
         unique case (st_q)
            SQ_IDLE: if (grant) begin
               st_q     <= SQ_FETCH;
               idx_q    <= grant_start;
               run_kind <= grant_kind;
            end
            SQ_FETCH: begin
               msg       <= rins.msg;
               cnt_q     <= rins.delay;
               nxt_q     <= rnext;
               msg_valid <= 1'b1;
               st_q      <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (cnt_q == 8'd0) begin
                  if (nxt_q == SENT) begin
                     st_q <= SQ_IDLE;
                  end else begin
                     idx_q <= nxt_q;
                     st_q  <= SQ_FETCH;
                  end
               end else if (tick) begin
                  cnt_q <= cnt_q - 8'd1;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy = (st_q != SQ_IDLE);
   assign ridx = idx_q;

   // R2
   strobe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> busy);
   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);
   // R3
   delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_WAIT && cnt_q != 8'd0 && !tick) |=> $stable(cnt_q));
   // R4
   end_on_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(nxt_q) == SENT));
endmodule

// File: rtl/pwr_script_engine.sv
module pwr_script_engine
   import pse_pkg::*;
#(
   parameter int IDX_W    = 6,
   parameter int NPROC    = 3,
   parameter int TICK_DIV = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [3:0]       cfg_sel,
   input  logic [7:0]       cfg_wdata,
   input  logic             sleep_req,
   input  logic [NPROC-1:0] wake_req,
   input  logic [NPROC-1:0] warm_req,
   output logic             msg_valid,
   output logic [15:0]      msg,
   output logic [1:0]       run_kind,
   output logic             busy,
   output logic             cfg_err
);
   localparam int ADDR_W = IDX_W + 2;

   generate
      if (IDX_W < 2 || IDX_W > 6) begin : g_bad_idx
         $error("IDX_W must lie in 2..6");
      end
      if (NPROC < 2 || NPROC > 10) begin : g_bad_nproc
         $error("NPROC must lie in 2..10");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [7:0]        mem_wdata;
   logic [IDX_W-1:0]  st_sleep, st_wake_sh, st_wake_last, st_warm;
   logic [NPROC-1:0]  lvl_en, warm_en;
   logic              grant;
   run_kind_e         grant_kind;
   run_kind_e         kind_q;
   logic [IDX_W-1:0]  grant_start;
   logic [IDX_W-1:0]  ridx;
   script_ins_t       rins;

   pse_cfg_regs #(.IDX_W(IDX_W), .NPROC(NPROC), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .start_sleep(st_sleep), .start_wake_sh(st_wake_sh),
      .start_wake_last(st_wake_last), .start_warm(st_warm),
      .lvl_en(lvl_en), .warm_en(warm_en), .cfg_err(cfg_err)
   );

   pse_script_mem #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
      .wdata(mem_wdata), .ridx(ridx), .rins(rins)
   );

   pse_event_arb #(.IDX_W(IDX_W), .NPROC(NPROC)) u_arb (
      .clk(clk), .rst_n(rst_n), .idle(~busy),
      .sleep_req(sleep_req), .wake_req(wake_req), .warm_req(warm_req),
      .lvl_en(lvl_en), .warm_en(warm_en),
      .start_sleep(st_sleep), .start_wake_sh(st_wake_sh),
      .start_wake_last(st_wake_last), .start_warm(st_warm),
      .grant(grant), .grant_kind(grant_kind), .grant_start(grant_start)
   );

   pse_sequencer #(.IDX_W(IDX_W), .TICK_DIV(TICK_DIV)) u_seq (
      .clk(clk), .rst_n(rst_n), .grant(grant), .grant_kind(grant_kind),
      .grant_start(grant_start), .rins(rins), .ridx(ridx), .busy(busy),
      .msg_valid(msg_valid), .msg(msg), .run_kind(kind_q)
   );

   assign run_kind = kind_q;
endmodule

// File: tb/tb_pwr_script_engine.sv
module tb_pwr_script_engine;
   localparam int TICK_DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       cfg_we = 1'b0;
   logic [3:0] cfg_sel = '0;
   logic [7:0] cfg_wdata = '0;
   logic       sleep_req = 1'b0;
   logic [2:0] wake_req = '0;
   logic [2:0] warm_req = '0;
   logic       msg_valid, busy, cfg_err;
   logic [15:0] msg;
   logic [1:0] run_kind;

   pwr_script_engine #(.IDX_W(6), .NPROC(3), .TICK_DIV(TICK_DIV)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .sleep_req(sleep_req), .wake_req(wake_req),
      .warm_req(warm_req), .msg_valid(msg_valid), .msg(msg),
      .run_kind(run_kind), .busy(busy), .cfg_err(cfg_err)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_mem [256];
   int m_addr, m_st_sleep, m_st_wsh, m_st_wlast, m_st_warm;
   int m_lvl [3];
   int m_wen [3];
   int m_prev [3];
   int m_div, m_phase, m_idx, m_cnt, m_nxt, m_msg, m_kind;
   bit m_msgv, m_err;

   always @(posedge clk) begin
      bit tick, g;
      int g_kind, g_start;
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = 0;
         m_addr = 0; m_st_sleep = 0; m_st_wsh = 0; m_st_wlast = 0; m_st_warm = 0;
         for (int p = 0; p < 3; p++) begin m_lvl[p] = 0; m_wen[p] = 0; m_prev[p] = 0; end
         m_div = 0; m_phase = 0; m_idx = 0; m_cnt = 0; m_nxt = 0; m_msg = 0; m_kind = 0;
         m_msgv = 0; m_err = 0;
      end else begin
         tick = (m_div == TICK_DIV - 1);
         g = 0; g_kind = 0; g_start = 0;
         if (m_phase == 0) begin
            for (int p = 0; p < 3; p++)
               if (!g && warm_req[p] && m_wen[p] != 0) begin g = 1; g_kind = 3; g_start = m_st_warm; end
            for (int p = 0; p < 3; p++)
               if (!g && wake_req[p] && (m_lvl[p] != 0 || m_prev[p] == 0)) begin
                  g = 1; g_kind = (p == 2) ? 2 : 1; g_start = (p == 2) ? m_st_wlast : m_st_wsh;
               end
            if (!g && sleep_req) begin g = 1; g_kind = 0; g_start = m_st_sleep; end
         end
         if (cfg_we) begin
            if (m_phase != 0) m_err = 1;
            else case (int'(cfg_sel))
               0: m_addr = cfg_wdata;
               1: m_mem[m_addr] = cfg_wdata;
               2: m_st_sleep = cfg_wdata % 64;
               3: m_st_wsh = cfg_wdata % 64;
               4: m_st_wlast = cfg_wdata % 64;
               5: m_st_warm = cfg_wdata % 64;
               6, 7, 8: begin
                  m_lvl[cfg_sel - 6] = cfg_wdata[3];
                  m_wen[cfg_sel - 6] = cfg_wdata[4];
               end
               default: ;
            endcase
         end
         m_msgv = 0;
         case (m_phase)
            0: if (g) begin m_phase = 1; m_idx = g_start; m_kind = g_kind; end
            1: begin
               m_msg  = m_mem[m_idx*4] * 256 + m_mem[m_idx*4+1];
               m_cnt  = m_mem[m_idx*4+2];
               m_nxt  = m_mem[m_idx*4+3] % 64;
               m_msgv = 1;
               m_phase = 2;
            end
            default: begin
               if (m_cnt == 0) begin
                  if (m_nxt == 63) m_phase = 0;
                  else begin m_idx = m_nxt; m_phase = 1; end
               end else if (tick) m_cnt--;
            end
         endcase
         for (int p = 0; p < 3; p++) m_prev[p] = wake_req[p];
         m_div = (m_div + 1) % TICK_DIV;
      end
   end

   // cycle compare against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2/R3/R4 busy vs model", busy, (m_phase != 0));
         chk("R2 msg_valid vs model", msg_valid, m_msgv);
         if (m_msgv) chk("R1/R3 msg vs model", msg, m_msg);
         if (m_phase != 0) chk("R5 run_kind vs model", run_kind, m_kind);
         chk("R10 cfg_err vs model", cfg_err, m_err);
      end
   end

   logic [15:0] got [$];
   always @(negedge clk) if (rst_n && msg_valid) got.push_back(msg);

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog (all R) actual cycles=%0d expected below 100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic wr(input int sel, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_ins(input int idx, input int m, input int dly, input int nxt);
      wr(0, idx*4);     wr(1, m >> 8);
      wr(0, idx*4 + 1); wr(1, m & 255);
      wr(0, idx*4 + 2); wr(1, dly);
      wr(0, idx*4 + 3); wr(1, nxt);
   endtask

   task automatic wait_busy(input string tag, input int kind);
      int w = 0;
      while (!busy && w < 50) begin @(negedge clk); w++; end
      chk({tag, " start"}, busy, 1);
      chk({tag, " kind"}, run_kind, kind);
   endtask

   task automatic wait_idle(input string tag);
      int w = 0;
      while (busy && w < 3000) begin @(negedge clk); w++; end
      chk({tag, " end"}, busy, 0);
   endtask

   task automatic quiet(input string tag, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) seen++; end
      chk(tag, seen, 0);
   endtask

   task automatic chk_seq(input string tag, input int n, input int a, input int b, input int c);
      int e [3];
      e[0] = a; e[1] = b; e[2] = c;
      chk({tag, " count"}, got.size(), n);
      for (int i = 0; i < n && i < got.size(); i++) chk(tag, got[i], e[i]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 busy after reset", busy, 0);
      chk("R11 msg_valid after reset", msg_valid, 0);
      chk("R11 cfg_err after reset", cfg_err, 0);
      rst_n = 1'b1;

      put_ins('h2B, 'h1A20, 3, 'h2C);
      put_ins('h2C, 'h1B40, 1, 'h3F);
      put_ins('h05, 'h5550, 0, 'h3F);
      put_ins('h2F, 'h207E, 0, 'h30);
      put_ins('h30, 'h20FE, 5, 'h31);
      put_ins('h31, 'h219E, 2, 'hFF);
      put_ins('h10, 'h8123, 2, 'h3F);
      put_ins('h38, 'h01B0, 2, 'h3A);
      put_ins('h39, 'hDEAD, 0, 'h3F);
      put_ins('h3A, 'h207F, 'h60, 'h3F);
      wr(2, 'h2B); wr(3, 'h2F); wr(4, 'h10); wr(5, 'h38);
      wr(6, 'h10); wr(7, 'h08); wr(8, 'h10);
      wr(9, 'hFF);

      // R1 R4: sleep script through the linked store
      got.delete();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      wait_busy("R1 sleep", 0);
      wait_idle("R4 sleep");
      chk_seq("R1/R4 sleep messages", 2, 'h1A20, 'h1B40, 0);

      // R8 edge lane 0, R3 zero delay and R4 upper link bits
      got.delete();
      @(negedge clk); wake_req[0] = 1'b1;
      wait_busy("R8 edge wake", 1);
      wait_idle("R3 wake");
      chk_seq("R3/R4 wake messages", 3, 'h207E, 'h20FE, 'h219E);
      quiet("R8 edge held high no rerun", 10);
      wake_req[0] = 1'b0;

      // R8 level lane 1
      got.delete();
      @(negedge clk); wake_req[1] = 1'b1;
      wait_busy("R8 level wake", 1);
      wait_idle("R8 level wake");
      @(negedge clk);
      chk("R8 level rerun busy", busy, 1);
      wake_req[1] = 1'b0;
      wait_idle("R8 level rerun");
      chk("R8 level run count", got.size(), 6);

      // R6 lane 2 own start index
      got.delete();
      @(negedge clk); wake_req[2] = 1'b1;
      wait_busy("R6 last lane", 2);
      wait_idle("R6 last lane");
      chk_seq("R6 last lane messages", 1, 'h8123, 0, 0);
      wake_req[2] = 1'b0;

      // R7 disabled warm
      @(negedge clk); warm_req[1] = 1'b1;
      quiet("R7 warm disabled ignored", 8);
      warm_req[1] = 1'b0;

      // R5 R9 collision of all requests
      got.delete();
      @(negedge clk); sleep_req = 1'b1; wake_req[2] = 1'b1; warm_req[2] = 1'b1;
      @(negedge clk); warm_req[2] = 1'b0;
      wait_busy("R5 warm wins", 3);
      wait_idle("R7 warm");
      chk_seq("R7 warm messages", 2, 'h01B0, 'h207F, 0);
      got.delete();
      wait_busy("R9 lost edge, sleep next", 0);
      sleep_req = 1'b0;
      wait_idle("R9 sleep");
      chk_seq("R9 sleep after warm", 2, 'h1A20, 'h1B40, 0);
      wake_req[2] = 1'b0;

      // R5 wake over sleep
      @(negedge clk); sleep_req = 1'b1; wake_req[0] = 1'b1;
      wait_busy("R5 wake over sleep", 1);
      sleep_req = 1'b0; wake_req[0] = 1'b0;
      wait_idle("R5 wake");

      // R12 write and grant in the same idle cycle
      got.delete();
      @(negedge clk); sleep_req = 1'b1; cfg_we = 1'b1; cfg_sel = 4'd2; cfg_wdata = 8'h05;
      @(negedge clk); sleep_req = 1'b0; cfg_we = 1'b0;
      wait_busy("R12 collide", 0);
      wait_idle("R12 collide");
      chk_seq("R12 old start used", 2, 'h1A20, 'h1B40, 0);
      chk("R12 no error", cfg_err, 0);
      got.delete();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      wait_busy("R12 next", 0);
      wait_idle("R12 next");
      chk_seq("R12 new start used", 1, 'h5550, 0, 0);

      // R10 write while busy
      got.delete();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0; cfg_we = 1'b1; cfg_sel = 4'd2; cfg_wdata = 8'h2B;
      chk("R10 busy during write", busy, 1);
      @(negedge clk); cfg_we = 1'b0;
      wait_idle("R10 run");
      chk("R10 error set", cfg_err, 1);
      got.delete();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      wait_busy("R10 check", 0);
      wait_idle("R10 check");
      chk_seq("R10 start unchanged", 1, 'h5550, 0, 0);
      wr(2, 'h2B);
      chk("R10 error sticky", cfg_err, 1);

      repeat (5) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule